// File: doc/BRIEF.md
# Flash In-System Programming Controller

This block lets a small processor program its own program flash while installed on the board. The processor sees a byte-wide register bus. Through it the processor loads a 16-bit target address and a data byte, and sets a write-timing value. It then issues read, byte-write, page-erase, mass-erase or exit commands through a control register. The controller drives a simple synchronous flash array model with an address, write data and one strobe per operation. It times each write or erase itself and reports busy and error status back on the bus.

The controller also chooses where the processor starts after reset. A persistent option byte lives in flash at 0x7FFF. The processor reaches it through the alias address 0xFFFF. After every reset, and after an exit command, the controller fetches that byte and holds the processor in reset while it does so. It then presents the boot-select bit: 0 means start in boot ROM, 1 means start at flash address 0x0000. A processor input tells the controller whether code is currently running from boot ROM, and only such code may issue commands.

Top module: `fisp_ctrl`

## Requirements
- R1: Register offsets on `reg_addr` are 0 address-high (bits 15..8), 1 address-low (bits 7..0), 2 read data (read-only), 3 write data, 4 write timing and 5 control. Writing value 1 to control reads flash. It pulses `fl_rd` in that cycle with the held address. The flash returns the byte on the next edge, and the read-data register captures it on the edge after that. Reading offset 2 therefore shows the new byte two bus cycles after the command cycle, and the old value one cycle after.
- R2: While and after reset, both address registers, the timing register and the error flag read 0. Control reads back as {busy, error, 5'b0, boot_select}.
- R3: Writes to either address register while busy is 1 leave it unchanged.
- R4: Control value 3 erases the 64-byte page that starts at the held address. If address bits 5..0 are not zero, no strobe is issued, busy stays 0 and the error bit is set.
- R5: Control value 4 mass-erases the array only when the address is 0x0000. Any other address issues no strobe and sets the error bit. Each accepted command rewrites the error bit.
- R6: Control value 2 writes the write-data byte with a one-cycle `fl_wr` pulse. After a write or an accepted erase, busy reads 1 for exactly 8×(N+1) cycles, where N is the timing register.
- R7: A read or write at address 0xFFFF is sent to flash address 0x7FFF.
- R8: After reset, `cpu_hold` is high while the option byte at 0x7FFF is fetched. `boot_flash` then shows its bit 0, and an empty (zero) option byte gives 0.
- R9: Changing the option byte does not change `boot_flash` until a reset or a control value 5 (exit) command triggers a new fetch. The exit command raises `cpu_hold` for two cycles.
- R10: When `cpu_in_rom` is 0, control writes issue no strobe and start nothing.
- R11: Control writes while busy is 1 are ignored: no strobe, and the read data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_in_rom | input | 1 | Processor is currently executing from boot ROM |
| reg_addr | input | 3 | Register offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the current offset |
| fl_addr | output | 16 | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, valid the cycle after `fl_rd` |
| fl_rd | output | 1 | Flash read strobe |
| fl_wr | output | 1 | Flash byte program strobe |
| fl_perase | output | 1 | Flash page erase strobe |
| fl_merase | output | 1 | Flash mass erase strobe |
| cpu_hold | output | 1 | Keeps the processor in reset while the boot vector is fetched |
| boot_flash | output | 1 | 1: start at flash 0x0000, 0: start in boot ROM |

## Verification
The assertions assume that the flash array answers a read strobe on the next edge and needs no handshake. They also assume that software polls the busy bit rather than relying on a fixed delay. The bench flash model meets the first assumption, and the bench waits on the busy bit before every new command except those deliberately issued while busy. The assertions also take `cpu_in_rom` to be steady around command writes; the bench changes it only between commands while the controller is idle.

// File: rtl/fisp_pkg.sv
package fisp_pkg;
  typedef enum logic [2:0] {
    REG_ADHI = 3'd0,
    REG_ADLO = 3'd1,
    REG_RDAT = 3'd2,
    REG_WDAT = 3'd3,
    REG_TIME = 3'd4,
    REG_CTRL = 3'd5
  } reg_sel_e;

  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_READ   = 3'd1,
    CMD_WRITE  = 3'd2,
    CMD_PERASE = 3'd3,
    CMD_MERASE = 3'd4,
    CMD_EXIT   = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    LD_REQ = 2'd0,
    LD_CAP = 2'd1,
    LD_RUN = 2'd2
  } ld_state_e;
endpackage

// File: rtl/fisp_rst_sync.sv
module fisp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fisp_timer.sv
module fisp_timer #(
  parameter int unsigned TW       = 8,
  parameter int unsigned SCALE_SH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] tval,
  output logic          busy
);
  localparam int unsigned CW = TW + SCALE_SH + 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)            cnt_d = (CW'(tval) + CW'(1)) << SCALE_SH;
    else if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/fisp_boot.sv
module fisp_boot
  import fisp_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned OPT_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [DW-1:0] fl_rdata,
  output logic          ld_rd,
  output logic          hold,
  output logic          boot_flash
);
  ld_state_e st_q, st_d;
  logic      flag_q, flag_d;

  always_comb begin
    st_d   = st_q;
    flag_d = flag_q;
    unique case (st_q)
      LD_REQ: st_d = LD_CAP;
      LD_CAP: begin
        flag_d = fl_rdata[OPT_BIT];
        st_d   = LD_RUN;
      end
      LD_RUN: if (restart) st_d = LD_REQ;
      default: st_d = LD_REQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LD_REQ;
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      flag_q <= flag_d;
    end
  end

  assign ld_rd      = (st_q == LD_REQ);
  assign hold       = (st_q != LD_RUN);
  assign boot_flash = flag_q;
endmodule

// File: rtl/fisp_ctrl.sv
module fisp_ctrl
  import fisp_pkg::*;
#(
  parameter int unsigned       DW         = 8,
  parameter int unsigned       PAGE_BYTES = 64,
  parameter logic [2*DW-1:0]   OPT_ALIAS  = 16'hFFFF,
  parameter logic [2*DW-1:0]   OPT_PHYS   = 16'h7FFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_in_rom,
  input  logic [2:0]      reg_addr,
  input  logic            reg_wen,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic [2*DW-1:0] fl_addr,
  output logic [DW-1:0]   fl_wdata,
  input  logic [DW-1:0]   fl_rdata,
  output logic            fl_rd,
  output logic            fl_wr,
  output logic            fl_perase,
  output logic            fl_merase,
  output logic            cpu_hold,
  output logic            boot_flash
);
  localparam int unsigned AW      = 2 * DW;
  localparam int unsigned PG_BITS = $clog2(PAGE_BYTES);

  logic          rst_i;
  logic [DW-1:0] adhi_q, adhi_d, adlo_q, adlo_d;
  logic [DW-1:0] rdat_q, rdat_d, wdat_q, wdat_d, tim_q, tim_d;
  logic          err_q, err_d, rdp_q, rdp_d;
  logic          tmr_busy, ld_busy, ld_rd, busy;
  logic [AW-1:0] addr;
  logic          accept, aligned, at_zero;
  logic          do_rd, do_wr, pe_ok, pe_bad, me_ok, me_bad, do_exit;
  cmd_e          cmd;

  fisp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i)
  );

  assign addr    = {adhi_q, adlo_q};
  assign busy    = tmr_busy | ld_busy;
  assign cmd     = cmd_e'(reg_wdata[2:0]);
  assign accept  = reg_wen && (reg_addr == REG_CTRL) && cpu_in_rom && !busy;
  assign aligned = (addr[PG_BITS-1:0] == '0);
  assign at_zero = (addr == '0);
  assign do_rd   = accept && (cmd == CMD_READ);
  assign do_wr   = accept && (cmd == CMD_WRITE);
  assign pe_ok   = accept && (cmd == CMD_PERASE) && aligned;
  assign pe_bad  = accept && (cmd == CMD_PERASE) && !aligned;
  assign me_ok   = accept && (cmd == CMD_MERASE) && at_zero;
  assign me_bad  = accept && (cmd == CMD_MERASE) && !at_zero;
  assign do_exit = accept && (cmd == CMD_EXIT);

  fisp_timer #(.TW(DW), .SCALE_SH(3)) u_tmr (
    .clk(clk), .rst_n(rst_i), .start(do_wr | pe_ok | me_ok),
    .tval(tim_q), .busy(tmr_busy)
  );

  fisp_boot #(.DW(DW), .OPT_BIT(0)) u_boot (
    .clk(clk), .rst_n(rst_i), .restart(do_exit), .fl_rdata(fl_rdata),
    .ld_rd(ld_rd), .hold(ld_busy), .boot_flash(boot_flash)
  );

  always_comb begin
    adhi_d = adhi_q;
    adlo_d = adlo_q;
    wdat_d = wdat_q;
    tim_d  = tim_q;
    rdat_d = rdat_q;
    err_d  = err_q;
    rdp_d  = do_rd;
    if (reg_wen) begin
      unique case (reg_addr)
        REG_ADHI: if (!busy) adhi_d = reg_wdata;
        REG_ADLO: if (!busy) adlo_d = reg_wdata;
        REG_WDAT: wdat_d = reg_wdata;
        REG_TIME: tim_d  = reg_wdata;
        default:  ;
      endcase
    end
    if (rdp_q)  rdat_d = fl_rdata;
    if (accept) err_d  = pe_bad | me_bad;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      adhi_q <= '0;
      adlo_q <= '0;
      wdat_q <= '0;
      tim_q  <= '0;
      rdat_q <= '0;
      err_q  <= 1'b0;
      rdp_q  <= 1'b0;
    end else begin
      adhi_q <= adhi_d;
      adlo_q <= adlo_d;
      wdat_q <= wdat_d;
      tim_q  <= tim_d;
      rdat_q <= rdat_d;
      err_q  <= err_d;
      rdp_q  <= rdp_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      REG_ADHI: reg_rdata = adhi_q;
      REG_ADLO: reg_rdata = adlo_q;
      REG_RDAT: reg_rdata = rdat_q;
      REG_WDAT: reg_rdata = wdat_q;
      REG_TIME: reg_rdata = tim_q;
      REG_CTRL: reg_rdata = {busy, err_q, {(DW-3){1'b0}}, boot_flash};
      default:  reg_rdata = '0;
    endcase
  end

  assign fl_addr   = (ld_rd || addr == OPT_ALIAS) ? OPT_PHYS : addr;
  assign fl_wdata  = wdat_q;
  assign fl_rd     = do_rd | ld_rd;
  assign fl_wr     = do_wr;
  assign fl_perase = pe_ok;
  assign fl_merase = me_ok;
  assign cpu_hold  = ld_busy;
endmodule

// File: rtl/fisp_ctrl_chk.sv
module fisp_ctrl_chk #(
  parameter int unsigned AW      = 16,
  parameter int unsigned PG_BITS = 6
) (
  input logic          clk,
  input logic          rst_i,
  input logic          cpu_in_rom,
  input logic          reg_wen,
  input logic [2:0]    reg_addr,
  input logic [AW-1:0] fl_addr,
  input logic          fl_rd,
  input logic          fl_wr,
  input logic          fl_perase,
  input logic          fl_merase,
  input logic          busy,
  input logic          tmr_busy,
  input logic [7:0]    adhi_q,
  input logic [7:0]    adlo_q,
  input logic          cpu_hold,
  input logic          boot_flash
);
  logic mod_op;
  assign mod_op = fl_wr | fl_perase | fl_merase;

  assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({fl_rd, fl_wr, fl_perase, fl_merase}));

  assert_adhi_frozen_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && reg_wen && reg_addr == 3'd0) |=> $stable(adhi_q));

  assert_adlo_frozen_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && reg_wen && reg_addr == 3'd1) |=> $stable(adlo_q));

  assert_page_aligned_R4: assert property (@(posedge clk) disable iff (!rst_i)
    fl_perase |-> (fl_addr[PG_BITS-1:0] == '0));

  assert_mass_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_i)
    fl_merase |-> (fl_addr == '0));

  assert_busy_follows_R6: assert property (@(posedge clk) disable iff (!rst_i)
    mod_op |=> tmr_busy);

  assert_vector_steady_R9: assert property (@(posedge clk) disable iff (!rst_i)
    (!cpu_hold && $past(!cpu_hold)) |-> $stable(boot_flash));

  assert_rom_only_R10: assert property (@(posedge clk) disable iff (!rst_i)
    !cpu_in_rom |-> !mod_op);

  assert_idle_only_R11: assert property (@(posedge clk) disable iff (!rst_i)
    busy |-> !mod_op);
endmodule

bind fisp_ctrl fisp_ctrl_chk #(.AW(AW), .PG_BITS(PG_BITS)) u_chk (
  .clk(clk), .rst_i(rst_i), .cpu_in_rom(cpu_in_rom), .reg_wen(reg_wen),
  .reg_addr(reg_addr), .fl_addr(fl_addr), .fl_rd(fl_rd), .fl_wr(fl_wr),
  .fl_perase(fl_perase), .fl_merase(fl_merase), .busy(busy),
  .tmr_busy(tmr_busy), .adhi_q(adhi_q), .adlo_q(adlo_q),
  .cpu_hold(cpu_hold), .boot_flash(boot_flash)
);

// File: tb/fisp_ctrl_tb.sv
module fisp_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, cpu_in_rom, reg_wen;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata, fl_wdata, fl_rdata;
  logic [15:0] fl_addr;
  logic        fl_rd, fl_wr, fl_perase, fl_merase, cpu_hold, boot_flash;

  int checks = 0;
  int fails  = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [7:0] fmem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  fisp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_in_rom(cpu_in_rom), .reg_addr(reg_addr),
    .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_perase(fl_perase),
    .fl_merase(fl_merase), .cpu_hold(cpu_hold), .boot_flash(boot_flash)
  );

  // flash array model: erased bytes read as zero
  always @(posedge clk) begin
    if (fl_rd) begin
      fl_rdata <= fmem.exists(int'(fl_addr)) ? fmem[int'(fl_addr)] : 8'h00;
      rd_cnt++;
    end
    if (fl_wr) begin
      fmem[int'(fl_addr)] = fl_wdata;
      wr_cnt++;
    end
    if (fl_perase) begin
      for (int i = 0; i < 64; i++) fmem.delete(int'(fl_addr) + i);
      wr_cnt++;
    end
    if (fl_merase) begin
      fmem.delete();
      wr_cnt++;
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_run();
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_addr(input logic [15:0] a);
    wreg(3'd0, a[15:8]);
    wreg(3'd1, a[7:0]);
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] s;
    n = 0;
    rreg(3'd5, s);
    while (s[7] && n < 5000) begin
      n++;
      @(negedge clk);
      rreg(3'd5, s);
    end
  endtask

  task automatic fl_write(input logic [15:0] a, input logic [7:0] d);
    int n;
    set_addr(a);
    wreg(3'd3, d);
    wreg(3'd5, 8'd2);
    wait_idle(n);
  endtask

  task automatic fl_read(input logic [15:0] a, output logic [7:0] d);
    set_addr(a);
    wreg(3'd5, 8'd1);
    @(negedge clk);
    rreg(3'd2, d);
  endtask

  task automatic do_reset();
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (cpu_hold && n < 20) begin n++; @(negedge clk); end
  endtask

  initial begin
    logic [7:0] v, old;
    int n, w0, r0;
    rst_n = 1'b0; cpu_in_rom = 1'b1; reg_wen = 1'b0;
    reg_addr = 3'd0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);

    // R2: reset values
    rreg(3'd0, v); chk("R2 addr hi", v, 8'h00);
    rreg(3'd1, v); chk("R2 addr lo", v, 8'h00);
    rreg(3'd4, v); chk("R2 timing", v, 8'h00);
    rreg(3'd5, v); chk("R2 error bit", v[6], 0);
    chk("R8 hold in reset", cpu_hold, 1);
    rst_n = 1'b1;
    n = 0;
    while (cpu_hold && n < 20) begin n++; @(negedge clk); end
    chk("R8 hold released", cpu_hold, 0);
    chk("R8 empty option -> boot rom", boot_flash, 0);

    // R6: busy window sweep over timing values
    for (int t = 0; t < 4; t++) begin
      wreg(3'd4, 8'(t));
      set_addr(16'h0100 + 16'(t));
      wreg(3'd3, 8'hA0 + 8'(t));
      wreg(3'd5, 8'd2);
      wait_idle(n);
      chk("R6 busy cycles", n, 8 * (t + 1));
    end
    wreg(3'd4, 8'd0);

    // R1: write/read sweep
    for (int i = 0; i < 16; i++) begin
      fl_write(16'(((i * 16'h0831) ^ 16'h1234) & 16'h3FFF), 8'(i * 37 + 5));
    end
    for (int i = 0; i < 16; i++) begin
      fl_read(16'(((i * 16'h0831) ^ 16'h1234) & 16'h3FFF), v);
      chk("R1 readback", v, (i * 37 + 5) & 8'hFF);
    end
    for (int t = 0; t < 4; t++) begin
      fl_read(16'h0100 + 16'(t), v);
      chk("R6 timed write data", v, 8'hA0 + t);
    end

    // R1: read latency
    fl_write(16'h0033, 8'h5C);
    fl_read(16'h0100, old);
    set_addr(16'h0033);
    wreg(3'd5, 8'd1);
    rreg(3'd2, v); chk("R1 rdata one cycle after", v, old);
    @(negedge clk);
    rreg(3'd2, v); chk("R1 rdata two cycles after", v, 8'h5C);

    // R3 and R11: writes while busy
    wreg(3'd4, 8'd3);
    set_addr(16'h0400);
    wreg(3'd3, 8'h77);
    wreg(3'd5, 8'd2);
    wreg(3'd0, 8'h55);
    wreg(3'd1, 8'hAA);
    rreg(3'd0, v); chk("R3 addr hi frozen", v, 8'h04);
    rreg(3'd1, v); chk("R3 addr lo frozen", v, 8'h00);
    r0 = rd_cnt; w0 = wr_cnt;
    wreg(3'd5, 8'd1);
    wreg(3'd5, 8'd2);
    @(negedge clk);
    chk("R11 read ignored", rd_cnt, r0);
    chk("R11 write ignored", wr_cnt, w0);
    rreg(3'd2, v); chk("R11 rdata kept", v, 8'h5C);
    wait_idle(n);
    wreg(3'd4, 8'd0);

    // R4: page erase
    fl_write(16'h0240, 8'h11);
    fl_write(16'h0241, 8'h22);
    fl_write(16'h027F, 8'h33);
    fl_write(16'h0280, 8'h44);
    set_addr(16'h0240);
    wreg(3'd5, 8'd3);
    rreg(3'd5, v); chk("R4 erase busy", v[7], 1);
    wait_idle(n);
    chk("R4 erase duration", n, 8);
    fl_read(16'h0240, v); chk("R4 first byte erased", v, 0);
    fl_read(16'h0241, v); chk("R4 middle erased", v, 0);
    fl_read(16'h027F, v); chk("R4 last byte erased", v, 0);
    fl_read(16'h0280, v); chk("R4 next page kept", v, 8'h44);
    w0 = wr_cnt;
    set_addr(16'h0281);
    wreg(3'd5, 8'd3);
    rreg(3'd5, v);
    chk("R4 misaligned error", v[6], 1);
    chk("R4 misaligned not busy", v[7], 0);
    chk("R4 misaligned no strobe", wr_cnt, w0);
    fl_read(16'h0280, v); chk("R4 data intact", v, 8'h44);
    rreg(3'd5, v); chk("R5 error cleared by next command", v[6], 0);

    // R5: mass erase
    w0 = wr_cnt;
    set_addr(16'h0010);
    wreg(3'd5, 8'd4);
    rreg(3'd5, v);
    chk("R5 nonzero address error", v[6], 1);
    chk("R5 nonzero not busy", v[7], 0);
    chk("R5 nonzero no strobe", wr_cnt, w0);
    fl_read(16'h0280, v); chk("R5 data intact", v, 8'h44);
    set_addr(16'h0000);
    wreg(3'd5, 8'd4);
    wait_idle(n);
    chk("R5 mass erase duration", n, 8);
    fl_read(16'h0280, v); chk("R5 array cleared", v, 0);
    fl_read(16'h0033, v); chk("R5 array cleared 2", v, 0);

    // R10: commands ignored outside boot ROM
    cpu_in_rom = 1'b0;
    w0 = wr_cnt; r0 = rd_cnt;
    set_addr(16'h0500);
    wreg(3'd3, 8'h99);
    wreg(3'd5, 8'd2);
    rreg(3'd5, v); chk("R10 no busy", v[7], 0);
    chk("R10 no write strobe", wr_cnt, w0);
    wreg(3'd5, 8'd1);
    chk("R10 no read strobe", rd_cnt, r0);
    cpu_in_rom = 1'b1;
    fl_read(16'h0500, v); chk("R10 byte untouched", v, 0);

    // R7: option alias
    fl_write(16'hFFFF, 8'h01);
    chk("R7 stored at 0x7FFF", fmem.exists(32'h7FFF) ? int'(fmem[32'h7FFF]) : 0, 1);
    fl_read(16'h7FFF, v); chk("R7 physical read", v, 8'h01);
    fl_read(16'hFFFF, v); chk("R7 alias read", v, 8'h01);
    chk("R9 no change before exit", boot_flash, 0);

    // R9: exit command reloads the vector
    wreg(3'd5, 8'd5);
    chk("R9 hold after exit", cpu_hold, 1);
    chk("R9 vector not yet", boot_flash, 0);
    @(negedge clk);
    chk("R9 hold second cycle", cpu_hold, 1);
    @(negedge clk);
    chk("R9 hold released", cpu_hold, 0);
    chk("R9 vector to flash", boot_flash, 1);

    // R8: vector survives reset, cleared option returns to boot ROM
    do_reset();
    chk("R8 reset reload", boot_flash, 1);
    rreg(3'd0, v); chk("R2 addr cleared again", v, 8'h00);
    fl_write(16'hFFFF, 8'h00);
    chk("R9 still flash", boot_flash, 1);
    do_reset();
    chk("R8 back to boot rom", boot_flash, 0);

    finish_run();
  end
endmodule